// File: doc/BRIEF.md
# Immediate Operand Collector

This block gathers an instruction's immediate operand out of a byte-wide prefetch queue. A one-cycle `go` pulse starts a fetch. `short_op`, sampled on that cycle, selects either a one-byte operand or a two-byte operand. The block then pops the needed bytes from the queue and never pops while the queue reports empty. It assembles the bytes least-significant first into a 16-bit value and sign-extends a single byte. When the value is ready it raises `done` for one cycle.

The queue returns popped data one cycle after the pop request. The block therefore captures each byte on the cycle after it asserts `q_pop`. If the queue is empty it waits, with the pop request low, and continues as soon as a byte appears. The published `operand` is held from one completion to the next. Later activity on the queue data bus does not disturb it.

Top module: `imm_fifo_reader`

## Requirements
- R1: With `short_op` high at the start, exactly one byte is popped and `operand` becomes that byte sign-extended to 16 bits (0x80 gives 0xFF80, 0x7F gives 0x007F).
- R2: With `short_op` low at the start, exactly two bytes are popped; the first popped byte forms bits 7:0 and the second bits 15:8 (0xAA then 0x55 gives 0x55AA).
- R3: A fetch starts on a cycle with `go` high while the block is idle. `q_pop` stays low in that cycle. A `go` pulse while a fetch is in progress is ignored.
- R4: `q_pop` is never high in a cycle in which `q_empty` is high.
- R5: A popped byte is taken from `q_data` in the cycle after the one with `q_pop` high. `done` rises two cycles after the final pop. With a non-empty queue, `done` appears 3 cycles after the `go` cycle for one byte and 4 cycles after it for two bytes.
- R6: `operand` changes only in a cycle in which `done` is high, and it ignores later values on `q_data`.
- R7: While a byte is still needed and the queue is empty, the block waits with `q_pop` low. It pops on the first cycle `q_empty` is low and always finishes once enough bytes arrive.
- R8: `done` lasts exactly one cycle. A later fetch replaces the held `operand`.
- R9: Synchronous reset (`rst` high) aborts any fetch and leaves `q_pop` low, `done` low and `operand` zero.
- R10: A change of `short_op` after the `go` cycle has no effect on the fetch in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | One-cycle fetch start pulse |
| short_op | input | 1 | 1: one-byte operand, 0: two-byte operand (sampled with `go`) |
| q_empty | input | 1 | Queue has no byte available |
| q_data | input | 8 | Queue read data, valid the cycle after a pop |
| q_pop | output | 1 | Pop request to the queue |
| operand | output | 16 | Assembled, held immediate value |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong issue count or a lost capture shows at the ports within one or two cycles. It appears as an extra or missing `q_pop` against the bench's queue, or as `done` arriving early, late or never. A byte taken on the wrong cycle, or stored into the wrong lane, reaches `operand` on the completion cycle. There it differs from the value predicted from the queue contents, because the bench drives junk onto `q_data` on every cycle that carries no popped byte. A stale size selection shows as a wrong pop count and a wrong upper byte on that same completion.

// File: rtl/imm_rd_pkg.sv
package imm_rd_pkg;

    // Width of the lane index carried in a capture request.
    localparam int unsigned IDX_W = 4;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } rd_state_e;

    // A capture request for the byte currently on the queue data bus.
    typedef struct packed {
        logic             valid;
        logic             last;
        logic [IDX_W-1:0] idx;
    } cap_req_t;

    // Number of bytes a fetch needs.
    function automatic int unsigned bytes_needed(input logic short_sel, input int unsigned lanes);
        return short_sel ? 1 : lanes;
    endfunction

endpackage

// File: rtl/imm_rd_sequencer.sv
module imm_rd_sequencer
    import imm_rd_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     short_sel,
    input  logic     fifo_none,
    output logic     accept,
    output logic     pop,
    output logic     short_q,
    output cap_req_t cap
);
    localparam int unsigned CW = $clog2(LANES + 1);

    rd_state_e       state_q;
    logic [CW-1:0]   need_q;
    logic [CW-1:0]   issued_q;
    logic            pend_q;
    logic [CW-1:0]   pend_idx_q;

    assign accept = (state_q == ST_IDLE) && start;
    assign pop    = (state_q == ST_FETCH) && (issued_q != need_q) && !fifo_none;

    always_comb begin
        cap.valid = pend_q;
        cap.idx   = IDX_W'(pend_idx_q);
        cap.last  = pend_q && (pend_idx_q == need_q - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            need_q     <= '0;
            issued_q   <= '0;
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            short_q    <= 1'b0;
        end else begin
            pend_q <= pop;
            if (pop) begin
                pend_idx_q <= issued_q;
                issued_q   <= issued_q + CW'(1);
            end
            if (cap.last) begin
                state_q <= ST_IDLE;
            end
            if (accept) begin
                state_q  <= ST_FETCH;
                short_q  <= short_sel;
                need_q   <= CW'(bytes_needed(short_sel, LANES));
                issued_q <= '0;
            end
        end
    end

endmodule

// File: rtl/imm_rd_assembler.sv
module imm_rd_assembler
    import imm_rd_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  logic                      short_q,
    input  cap_req_t                  cap,
    input  logic [BYTE_W-1:0]         rd_data,
    output logic [BYTE_W*LANES-1:0]   value,
    output logic                      finished
);
    localparam int unsigned RW = BYTE_W * LANES;

    logic [BYTE_W-1:0] lane_q  [LANES];
    logic [BYTE_W-1:0] lane_nx [LANES];
    logic [RW-1:0]     flat;
    logic [RW-1:0]     result;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit;
        assign hit        = cap.valid && (cap.idx == IDX_W'(g));
        assign lane_nx[g] = hit ? rd_data : lane_q[g];
        assign flat[g*BYTE_W +: BYTE_W] = lane_nx[g];

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                lane_q[g] <= '0;
            end else if (hit) begin
                lane_q[g] <= rd_data;
            end
        end
    end

    assign result = short_q ? {{(RW-BYTE_W){lane_nx[0][BYTE_W-1]}}, lane_nx[0]} : flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            value    <= '0;
            finished <= 1'b0;
        end else begin
            finished <= cap.last;
            if (cap.last) begin
                value <= result;
            end
        end
    end

endmodule

// File: rtl/imm_fifo_reader.sv
module imm_fifo_reader
    import imm_rd_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    go,
    input  logic                    short_op,
    input  logic                    q_empty,
    input  logic [BYTE_W-1:0]       q_data,
    output logic                    q_pop,
    output logic [BYTE_W*LANES-1:0] operand,
    output logic                    done
);
    logic     accept;
    logic     short_q;
    cap_req_t cap;

    imm_rd_sequencer #(.LANES(LANES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (go),
        .short_sel (short_op),
        .fifo_none (q_empty),
        .accept    (accept),
        .pop       (q_pop),
        .short_q   (short_q),
        .cap       (cap)
    );

    imm_rd_assembler #(.BYTE_W(BYTE_W), .LANES(LANES)) u_asm (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .short_q  (short_q),
        .cap      (cap),
        .rd_data  (q_data),
        .value    (operand),
        .finished (done)
    );

endmodule

// File: rtl/imm_fifo_reader_chk.sv
module imm_fifo_reader_chk #(
    parameter int unsigned RW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          q_empty,
    input logic          q_pop,
    input logic [RW-1:0] operand,
    input logic          done
);
    a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        q_empty |-> !q_pop);

    a_r5_done_two_after_last_pop: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(q_pop, 2) && !$past(q_pop)));

    a_r6_operand_moves_only_on_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(operand) |-> done);

    a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> (!q_pop && !done && operand == '0));

endmodule

bind imm_fifo_reader imm_fifo_reader_chk #(.RW(BYTE_W*LANES)) u_chk (.*);

// File: tb/tb_imm_fifo_reader.sv
module tb_imm_fifo_reader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic        short_op = 1'b0;
    logic        q_empty = 1'b1;
    logic [7:0]  q_data = 8'h00;
    logic        q_pop;
    logic [15:0] operand;
    logic        done;

    always #4 clk = ~clk;

    imm_fifo_reader dut (.*);

    byte unsigned fq[$];
    int n_cmp = 0, n_bad = 0, cyc = 0, done_count = 0;
    logic [7:0] staged;
    bit staged_v = 0, last_done = 0;

    // behavioural reference state
    bit m_busy = 0, m_short = 0, m_pend = 0, m_cmp = 0;
    int m_need = 0, m_issued = 0, m_got = 0;
    logic [15:0] m_asm = 0, m_imm = 0;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL R7 watchdog: actual %0d cycles expected < 20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_busy = 0; m_short = 0; m_pend = 0; m_cmp = 0;
        m_need = 0; m_issued = 0; m_got = 0; m_asm = 0; m_imm = 0;
        fq.delete(); staged_v = 0;
    endtask

    // One clock: compare against the model, advance it, serve the queue.
    task automatic tick();
        bit e_pop, was_busy;
        q_empty = (fq.size() == 0);
        #1;
        e_pop = m_busy && (m_issued < m_need) && !q_empty;
        check(q_pop === e_pop, "R4/R7 pop timing", 32'(q_pop), 32'(e_pop));
        check(done === m_cmp, "R5/R8 done timing", 32'(done), 32'(m_cmp));
        check(operand === m_imm, "R6 held operand", 32'(operand), 32'(m_imm));
        last_done = done;
        if (done) done_count++;
        was_busy = m_busy;
        m_cmp = 0;
        if (m_pend) begin
            m_asm[8*m_got +: 8] = q_data;
            m_got++;
            if (m_got == m_need) begin
                m_imm = m_short ? {{8{m_asm[7]}}, m_asm[7:0]} : m_asm;
                m_cmp = 1;
                m_busy = 0;
            end
        end
        m_pend = e_pop;
        if (e_pop) m_issued++;
        if (!was_busy && go) begin
            m_busy = 1; m_short = short_op; m_need = short_op ? 1 : 2;
            m_issued = 0; m_got = 0; m_asm = 0;
        end
        staged_v = 0;
        if (q_pop && fq.size() > 0) begin
            staged = fq.pop_front();
            staged_v = 1;
        end
        @(negedge clk);
        q_data = staged_v ? staged : 8'(cyc * 37 + 5);
    endtask

    task automatic fetch(input bit s, output int lat);
        lat = 0;
        short_op = s;
        go = 1;
        tick();
        go = 0;
        do begin
            tick();
            lat++;
        end while (!last_done && lat < 60);
    endtask

    int lat;
    int dc0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check(q_pop === 1'b0 && done === 1'b0, "R9 reset outputs", {q_pop, done}, 0);
        check(operand === 16'h0000, "R9 reset operand", 32'(operand), 0);
        @(negedge clk);

        // R1 negative byte, one pop only
        fq.push_back(8'h80); fq.push_back(8'h11);
        fetch(1, lat);
        check(operand === 16'hFF80, "R1 sign-extend 0x80", 32'(operand), 32'hFF80);
        check(fq.size() == 1, "R1 one byte popped", fq.size(), 1);
        check(lat == 3, "R5 short latency", lat, 3);
        tick();
        check(done === 1'b0, "R8 done one cycle", 32'(done), 0);
        fq.delete();

        // R1 positive byte
        fq.push_back(8'h7F);
        fetch(1, lat);
        check(operand === 16'h007F, "R1 sign-extend 0x7F", 32'(operand), 32'h007F);

        // R2 two bytes, little-endian
        fq.push_back(8'hAA); fq.push_back(8'h55); fq.push_back(8'h99);
        fetch(0, lat);
        check(operand === 16'h55AA, "R2 two-byte order", 32'(operand), 32'h55AA);
        check(fq.size() == 1, "R2 two bytes popped", fq.size(), 1);
        check(lat == 4, "R5 long latency", lat, 4);
        fq.delete();

        // R6 hold while the data bus changes
        repeat (2) tick();
        q_data = 8'h00;
        repeat (2) tick();
        check(operand === 16'h55AA, "R6 operand held", 32'(operand), 32'h55AA);

        // R7 wait on empty queue, resume when bytes arrive
        short_op = 0; go = 1; tick(); go = 0;
        repeat (5) tick();
        check(done_count == 3, "R7 no completion while empty", done_count, 3);
        fq.push_back(8'h34);
        repeat (3) tick();
        fq.push_back(8'h12);
        lat = 0;
        do begin tick(); lat++; end while (!last_done && lat < 60);
        check(operand === 16'h1234, "R7 resumed fetch", 32'(operand), 32'h1234);

        // R10 size change after go has no effect
        fq.push_back(8'hCD); fq.push_back(8'hAB);
        short_op = 0; go = 1; tick(); go = 0; short_op = 1;
        lat = 0;
        do begin tick(); lat++; end while (!last_done && lat < 60);
        check(operand === 16'hABCD, "R10 size latched", 32'(operand), 32'hABCD);
        check(fq.size() == 0, "R10 both bytes popped", fq.size(), 0);

        // R3 go during a fetch is ignored
        dc0 = done_count;
        short_op = 0; go = 1; tick(); go = 0;
        repeat (2) tick();
        short_op = 1; go = 1; tick(); go = 0; short_op = 0;
        fq.push_back(8'hEF); fq.push_back(8'h01);
        repeat (8) tick();
        check(operand === 16'h01EF, "R3 busy go ignored", 32'(operand), 32'h01EF);
        check(done_count - dc0 == 1, "R3 single completion", done_count - dc0, 1);

        // R8 new fetch overwrites
        fq.push_back(8'hFE);
        fetch(1, lat);
        check(operand === 16'hFFFE, "R8 overwrite", 32'(operand), 32'hFFFE);

        // R9 reset in the middle of a fetch
        fq.push_back(8'h21); fq.push_back(8'h43);
        short_op = 0; go = 1; tick(); go = 0;
        tick();
        rst = 1;
        repeat (2) @(negedge clk);
        #1;
        check(q_pop === 1'b0 && done === 1'b0, "R9 mid-fetch reset", {q_pop, done}, 0);
        check(operand === 16'h0000, "R9 operand cleared", 32'(operand), 0);
        rst = 0;
        model_reset();
        @(negedge clk);
        repeat (3) tick();

        summary();
        $finish;
    end
endmodule